// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps a 24-hour time of day as six BCD digits: seconds units and tens, minutes units and tens, hours units and tens. Each digit is its own small counter with its own modulus. A one-hertz enable pulse, qualified by a run input, advances the seconds-units digit. Every digit passes a one-cycle carry to the next more significant digit, so the whole chain advances from a single enable with no derived clocks.

A shared 4-bit preset value and six per-digit load strobes set the time. Each strobe writes the preset value into its own digit. When the hours read 23 and the minutes carry out, both hour digits return to zero, so 23:59:59 becomes 00:00:00. The block sits between a clock divider, which makes the one-hertz pulse, and a display scanner, which reads the six digits. Neither of those is part of this block.

Top module: `tod_counter_chain`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets all six digits to 0 on that edge.
- R2: The chain advances only when `tick_1hz` and `run` are both high at a clock edge. Otherwise every digit keeps its value, unless it is being loaded.
- R3: The seconds-units digit counts 0..9 and wraps to 0. The seconds-tens digit advances only when units wraps, counts 0..5 and wraps to 0.
- R4: The minutes-units digit (0..9) advances only when the seconds pass 59. The minutes-tens digit (0..5) advances only when minutes-units wraps.
- R5: The hours-units digit (0..9) advances only when the minutes pass 59. The hours-tens digit (0..2) advances only when hours-units wraps from 9.
- R6: When the hours read 23 and the minutes-tens carry fires, both hour digits become 0 on that edge. An advancing 23:59:59 therefore becomes 00:00:00.
- R7: A digit's carry to the next digit is high only in a cycle where that digit is enabled and holds its maximum. The carry lasts one cycle, and the digit reads 0 afterwards.
- R8: Each bit of `load_stb` controls one digit: bit 0 seconds units, bit 1 seconds tens, bit 2 minutes units, bit 3 minutes tens, bit 4 hours units, bit 5 hours tens. A digit whose strobe is high at an edge takes `load_val` on that edge.
- R9: A load takes priority over counting and over the hour wrap clear for its own digit. The carry the digit sends onward still depends on the value it held before the load.
- R10: A loaded value above the digit's maximum (9, 5, 9, 5, 9, 2 for bits 0..5) is stored as that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-hertz enable pulse, one clock wide |
| run | input | 1 | Run qualifier for the tick |
| load_val | input | 4 | Shared preset value for digit loads |
| load_stb | input | 6 | Per-digit load strobes (bit map in R8) |
| sec_ones | output | 4 | Seconds units digit |
| sec_tens | output | 4 | Seconds tens digit |
| min_ones | output | 4 | Minutes units digit |
| min_tens | output | 4 | Minutes tens digit |
| hr_ones | output | 4 | Hours units digit |
| hr_tens | output | 4 | Hours tens digit |

## Verification
Directed sequences preset the chain just below each carry boundary. They then tick with `run` low, then high, to show that the gate holds the time and that each carry ripples to the right digit. The sequences cover the 09:59:59 to 10:00:00 and 23:59:59 to 00:00:00 transitions, and the second one separates the hour wrap clear from an ordinary hours-tens wrap. Out-of-range presets show the clamp, and loads that arrive together with a tick or a wrap show that a load beats counting while the outgoing carry still depends on the old value. A long stretch of seeded random ticks, run levels, loads and occasional resets is compared every cycle against a bench model. It reaches ordering combinations that the directed cases miss.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 6;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Per-position modulus limit: sec units, sec tens, min units,
    // min tens, hour units, hour tens.
    function automatic int digit_max(input int idx);
        case (idx)
            0:       return 9;
            1:       return 5;
            2:       return 9;
            3:       return 5;
            4:       return 9;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/tod_digit.sv
module tod_digit #(
    parameter int W   = 4,
    parameter int MAX = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] value,
    output logic         carry
);

    localparam logic [W-1:0] MAXV = W'(MAX);

    logic [W-1:0] ld_clamped;

    always_comb begin
        ld_clamped = (ld_val > MAXV) ? MAXV : ld_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (ld)
            value <= ld_clamped;
        else if (clr)
            value <= '0;
        else if (cnt_en)
            value <= (value == MAXV) ? '0 : value + 1'b1;
    end

    assign carry = cnt_en && (value == MAXV);

    AST_DIGIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        value <= MAXV); // R3
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> value == '0); // R1
    AST_LOAD_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        (ld && ld_val > MAXV) |=> value == MAXV); // R10
    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ld && ld_val <= MAXV) |=> value == $past(ld_val)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ld && !clr && !cnt_en) |=> $stable(value)); // R2
    AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (carry && !ld) |=> value == '0); // R7

endmodule

// File: rtl/tod_hour_wrap.sv
module tod_hour_wrap #(
    parameter int W         = 4,
    parameter int WRAP_TENS = 2,
    parameter int WRAP_ONES = 3
) (
    input  logic [W-1:0] hr_tens,
    input  logic [W-1:0] hr_ones,
    input  logic         min_carry,
    output logic         wrap
);

    localparam logic [W-1:0] TENS_V = W'(WRAP_TENS);
    localparam logic [W-1:0] ONES_V = W'(WRAP_ONES);

    always_comb begin
        wrap = min_carry && (hr_tens == TENS_V) && (hr_ones == ONES_V);
    end

endmodule

// File: rtl/tod_counter_chain.sv
module tod_counter_chain
    import tod_pkg::*;
#(
    parameter int HOUR_WRAP_TENS = 2,
    parameter int HOUR_WRAP_ONES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_1hz,
    input  logic               run,
    input  logic [DIGIT_W-1:0] load_val,
    input  logic [NUM_DIGITS-1:0] load_stb,
    output logic [DIGIT_W-1:0] sec_ones,
    output logic [DIGIT_W-1:0] sec_tens,
    output logic [DIGIT_W-1:0] min_ones,
    output logic [DIGIT_W-1:0] min_tens,
    output logic [DIGIT_W-1:0] hr_ones,
    output logic [DIGIT_W-1:0] hr_tens
);

    localparam int HOUR_LO = NUM_DIGITS - 2;
    localparam int HOUR_HI = NUM_DIGITS - 1;

    bcd_t                digit [NUM_DIGITS];
    logic [NUM_DIGITS:0] en_chain;
    logic                hour_wrap;

    assign en_chain[0] = tick_1hz && run;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
            localparam int LIMIT = digit_max(gi);
            logic clr_this;
            if (gi >= HOUR_LO) begin : g_hour_clr
                assign clr_this = hour_wrap;
            end else begin : g_no_clr
                assign clr_this = 1'b0;
            end
            tod_digit #(
                .W   (DIGIT_W),
                .MAX (LIMIT)
            ) u_digit (
                .clk    (clk),
                .rst    (rst),
                .cnt_en (en_chain[gi]),
                .clr    (clr_this),
                .ld     (load_stb[gi]),
                .ld_val (load_val),
                .value  (digit[gi]),
                .carry  (en_chain[gi+1])
            );
        end
    endgenerate

    tod_hour_wrap #(
        .W         (DIGIT_W),
        .WRAP_TENS (HOUR_WRAP_TENS),
        .WRAP_ONES (HOUR_WRAP_ONES)
    ) u_wrap (
        .hr_tens   (digit[HOUR_HI]),
        .hr_ones   (digit[HOUR_LO]),
        .min_carry (en_chain[HOUR_LO]),
        .wrap      (hour_wrap)
    );

    assign sec_ones = digit[0];
    assign sec_tens = digit[1];
    assign min_ones = digit[2];
    assign min_tens = digit[3];
    assign hr_ones  = digit[HOUR_LO];
    assign hr_tens  = digit[HOUR_HI];

    AST_HOUR_WRAP_ONES: assert property (@(posedge clk) disable iff (rst)
        (hour_wrap && !load_stb[HOUR_LO]) |=> hr_ones == '0); // R6
    AST_HOUR_WRAP_TENS: assert property (@(posedge clk) disable iff (rst)
        (hour_wrap && !load_stb[HOUR_HI]) |=> hr_tens == '0); // R6
    AST_RUN_GATE: assert property (@(posedge clk) disable iff (rst)
        (!run && load_stb == '0) |=> ($stable(sec_ones) && $stable(min_ones)
                                      && $stable(hr_ones) && $stable(hr_tens))); // R2
    AST_SEC_TENS_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!load_stb[1] && sec_ones != 4'd9) |=> $stable(sec_tens)); // R3
    AST_MIN_ONES_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!load_stb[2] && !(sec_tens == 4'd5 && sec_ones == 4'd9)) |=> $stable(min_ones)); // R4

endmodule

// File: tb/tod_counter_chain_bench.sv
module tod_counter_chain_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       run = 1'b0;
    logic [3:0] load_val = '0;
    logic [5:0] load_stb = '0;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;

    int checks = 0;
    int errors = 0;
    int m [6];
    bit done = 0;

    always #2 clk = ~clk;

    tod_counter_chain u_tod_counter_chain (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .run(run),
        .load_val(load_val), .load_stb(load_stb),
        .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
        .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens)
    );

    function automatic int lim(input int i);
        case (i)
            0: return 9; 1: return 5; 2: return 9;
            3: return 5; 4: return 9; default: return 2;
        endcase
    endfunction

    function automatic int act(input int i);
        case (i)
            0: return int'(sec_ones); 1: return int'(sec_tens);
            2: return int'(min_ones); 3: return int'(min_tens);
            4: return int'(hr_ones);  default: return int'(hr_tens);
        endcase
    endfunction

    // Next-state model built from the requirements
    task automatic model_step(input bit r, input bit t, input bit g,
                              input logic [5:0] s, input int v);
        bit en [7];
        bit wrap;
        int nx [6];
        en[0] = t && g;
        for (int i = 0; i < 6; i++) en[i+1] = en[i] && (m[i] == lim(i));
        wrap = en[4] && m[5] == 2 && m[4] == 3;
        for (int i = 0; i < 6; i++) begin
            if (r)                    nx[i] = 0;
            else if (s[i])            nx[i] = (v > lim(i)) ? lim(i) : v;
            else if (wrap && i >= 4)  nx[i] = 0;
            else if (en[i])           nx[i] = (m[i] == lim(i)) ? 0 : m[i] + 1;
            else                      nx[i] = m[i];
        end
        for (int i = 0; i < 6; i++) m[i] = nx[i];
    endtask

    task automatic compare(input string tag);
        checks++;
        for (int i = 0; i < 6; i++) begin
            if (act(i) != m[i]) begin
                errors++;
                $display("FAIL %s digit %0d: actual %0d expected %0d", tag, i, act(i), m[i]);
                break;
            end
        end
    endtask

    task automatic cyc(input bit r, input bit t, input bit g,
                       input logic [5:0] s, input logic [3:0] v, input string tag);
        rst = r; tick_1hz = t; run = g; load_stb = s; load_val = v;
        model_step(r, t, g, s, int'(v));
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic preset(input int h, input int mi, input int s);
        cyc(0, 0, 0, 6'b000001, 4'(s % 10), "R8 load sec units");
        cyc(0, 0, 0, 6'b000010, 4'(s / 10), "R8 load sec tens");
        cyc(0, 0, 0, 6'b000100, 4'(mi % 10), "R8 load min units");
        cyc(0, 0, 0, 6'b001000, 4'(mi / 10), "R8 load min tens");
        cyc(0, 0, 0, 6'b010000, 4'(h % 10), "R8 load hour units");
        cyc(0, 0, 0, 6'b100000, 4'(h / 10), "R8 load hour tens");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20260413));
        for (int i = 0; i < 6; i++) m[i] = 0;
        @(negedge clk);
        cyc(1, 0, 0, 6'b0, 4'd0, "R1 reset state");
        cyc(1, 1, 1, 6'b111111, 4'd7, "R1 reset beats load and tick");

        preset(23, 59, 58);
        cyc(0, 1, 0, 6'b0, 4'd0, "R2 tick without run holds");
        cyc(0, 0, 1, 6'b0, 4'd0, "R2 run without tick holds");
        cyc(0, 1, 1, 6'b0, 4'd0, "R3 advance to 23:59:59");
        cyc(0, 1, 1, 6'b0, 4'd0, "R6 wrap to 00:00:00");
        if (hr_tens != 0 || hr_ones != 0 || min_tens != 0 || sec_ones != 0) begin
            errors++;
            $display("FAIL R6 wrap: actual %0d%0d expected 00", hr_tens, hr_ones);
        end
        checks++;

        preset(9, 59, 59);
        cyc(0, 1, 1, 6'b0, 4'd0, "R5 09:59:59 to 10:00:00");
        preset(19, 59, 59);
        cyc(0, 1, 1, 6'b0, 4'd0, "R5 hours units carry into tens");
        preset(12, 5, 59);
        cyc(0, 1, 1, 6'b0, 4'd0, "R4 seconds carry into minutes");
        cyc(0, 1, 1, 6'b0, 4'd0, "R7 carry lasts one cycle");

        cyc(0, 0, 0, 6'b100000, 4'd15, "R10 hour tens clamps to 2");
        cyc(0, 0, 0, 6'b000010, 4'd9, "R10 sec tens clamps to 5");
        cyc(0, 0, 0, 6'b001000, 4'd12, "R10 min tens clamps to 5");

        preset(23, 59, 59);
        cyc(0, 1, 1, 6'b010000, 4'd7, "R9 load beats hour wrap clear");
        preset(1, 2, 9);
        cyc(0, 1, 1, 6'b000001, 4'd4, "R9 load beats count, carry from old value");

        for (int k = 0; k < 4000; k++) begin
            bit r, t, g;
            logic [5:0] s;
            logic [3:0] v;
            r = ($urandom_range(0, 199) == 0);
            t = ($urandom_range(0, 9) < 7);
            g = ($urandom_range(0, 9) < 9);
            s = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'b0;
            v = 4'($urandom);
            cyc(r, t, g, s, v, "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule